// File: doc/BRIEF.md
# Converter Result Assembler and Formatter

This block sits behind a recycling analog-to-digital converter core. The core produces its result as a stream of 2-bit digit pairs, one pair per system clock, most significant pair first. The block gathers these pairs into a parallel word. The number of pairs depends on the chosen resolution. The block then left-justifies the word on a 10-bit data bus and fills the unused low bits with zeros. Finally it codes the word either as straight binary or as two's complement.

Finished words go into a small holding buffer that a host drains with read strobes. The buffer mode has two settings:
- In single-channel mode the buffer keeps only the newest result.
- In dual-channel mode it holds two results in arrival order, channel A first and channel B second.

The bus drive enable is raised only while both the chip select and the read strobe are low. A read completes on the rising edge of the read strobe and takes one entry from the buffer.

Top module: `conv_result_fmt`

## Requirements
- R1: With resolution code 00 (10 bits), five pairs taken on consecutive clocks starting with the one marked by `pair_start_i` form the result. The first pair lands in bus bits 9:8 and the last in bits 1:0. `done_o` is high for the one cycle that follows the clock edge taking the fifth pair.
- R2: With resolution code 10 (8 bits), four pairs form the result. It is placed in bus bits 9:2, and bits 1:0 read as zero.
- R3: With resolution code 01 (4 bits), two pairs form the result. It is placed in bus bits 9:6, and bits 5:0 read as zero.
- R4: Resolution code 11 (test) behaves exactly as code 00, taking five pairs and passing all ten bits through.
- R5: With `fmt_bin_i` = 1 the word is straight binary. With `fmt_bin_i` = 0 bus bit 9 is inverted, which gives the two's complement form of the offset-binary result.
- R6: `oe_o` is 1 only while `cs_n_i` and `rd_n_i` are both 0. While it is 1, `data_o` shows the oldest held result.
- R7: A read completes on a clock where `rd_n_i` is sampled 1 after being 0 on the previous clock, with `cs_n_i` at 0. It removes the oldest held result. A rising read strobe while `cs_n_i` is 1 removes nothing.
- R8: With `dual_i` = 1 the buffer keeps two results and returns them in arrival order. A result that completes while two are already held is dropped.
- R9: With `dual_i` = 0 a newly completed result replaces any held result.
- R10: A read when the buffer is empty leaves `data_o` at the last word read. After reset that word is zero.
- R11: A `pair_start_i` that arrives while a result is still being collected abandons the partial result and starts a new one with the pair it marks.
- R12: Resolution and format are sampled with the start pair. Changes to them during collection do not affect that result. `done_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_start_i | input | 1 | Marks the first (most significant) pair of a result |
| pair_i | input | 2 | Result digit pair for this clock |
| res_sel_i | input | 2 | Resolution code: 00=10 bits, 01=4 bits, 10=8 bits, 11=test (10 bits) |
| fmt_bin_i | input | 1 | 1 = straight binary, 0 = two's complement |
| dual_i | input | 1 | 1 = two-entry buffer, 0 = single entry |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low; read completes on its rise |
| done_o | output | 1 | One-cycle pulse when a result completes |
| data_o | output | 10 | Word presented on the data bus |
| oe_o | output | 1 | Bus drive enable |

## Verification
The stimulus covers all four resolution codes with random pair values under both codings. Comparing each with a bench-computed word shows whether the pair count, the justification shift and the MSB recode are each right.

Several directed sequences separate the buffer behaviours:
- Three results in dual mode expose ordering and the drop when full.
- Two results in single mode expose replacement.
- Reads of an empty buffer expose the hold of the last word.

Further sequences check the input sampling. A truncated collection followed by a new start shows restart handling. Changing the resolution and format after the start pair shows that both are sampled only once, at the start.

// File: rtl/conv_fmt_pkg.sv
package conv_fmt_pkg;

   typedef enum logic [1:0] {
      RES_FULL = 2'b00,
      RES_LOW  = 2'b01,
      RES_MID  = 2'b10,
      RES_TEST = 2'b11
   } res_e;

   // number of digit pairs a result of this resolution carries
   function automatic int unsigned pair_count(input res_e r, input int unsigned bus_w,
                                               input int unsigned mid_w, input int unsigned low_w,
                                               input int unsigned pair_w);
      case (r)
         RES_LOW: return low_w / pair_w;
         RES_MID: return mid_w / pair_w;
         default: return bus_w / pair_w;
      endcase
   endfunction

endpackage

// File: rtl/pair_assembler.sv
module pair_assembler
   import conv_fmt_pkg::*;
#(
   parameter int unsigned BUS_W  = 10,
   parameter int unsigned PAIR_W = 2,
   parameter int unsigned MID_W  = 8,
   parameter int unsigned LOW_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PAIR_W-1:0] pair_i,
   input  res_e              res_i,
   input  logic              fmt_i,
   output logic              done_o,
   output logic [BUS_W-1:0]  acc_o,
   output res_e              res_o,
   output logic              fmt_o
);
   localparam int unsigned FULL_P = BUS_W / PAIR_W;
   localparam int unsigned CW     = $clog2(FULL_P + 1);

   logic [BUS_W-1:0] acc_q, acc_nx;
   logic [CW-1:0]    cnt_q, cnt_nx, need;
   logic             busy_q, done_q, take, fin;
   res_e             res_q, res_eff;
   logic             fmt_q;

   always_comb begin
      res_eff = start_i ? res_i : res_q;
      need    = CW'(pair_count(res_eff, BUS_W, MID_W, LOW_W, PAIR_W));
      cnt_nx  = start_i ? CW'(1) : cnt_q + CW'(1);
      acc_nx  = start_i ? {{(BUS_W-PAIR_W){1'b0}}, pair_i}
                        : {acc_q[BUS_W-PAIR_W-1:0], pair_i};
      take    = start_i | busy_q;
      fin     = take && (cnt_nx == need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         res_q  <= RES_FULL;
         fmt_q  <= 1'b1;
      end else begin
         done_q <= fin;
         if (take) begin
            acc_q  <= acc_nx;
            cnt_q  <= cnt_nx;
            busy_q <= !fin;
         end
         if (start_i) begin
            res_q <= res_i;
            fmt_q <= fmt_i;
         end
      end
   end

   assign done_o = done_q;
   assign acc_o  = acc_q;
   assign res_o  = res_q;
   assign fmt_o  = fmt_q;
endmodule

// File: rtl/result_formatter.sv
module result_formatter
   import conv_fmt_pkg::*;
#(
   parameter int unsigned BUS_W  = 10,
   parameter int unsigned PAIR_W = 2,
   parameter int unsigned MID_W  = 8,
   parameter int unsigned LOW_W  = 4
) (
   input  logic [BUS_W-1:0] acc_i,
   input  res_e             res_i,
   input  logic             fmt_bin_i,
   output logic [BUS_W-1:0] word_o
);
   logic [BUS_W-1:0] just;

   always_comb begin
      case (res_i)
         RES_LOW: just = acc_i << (BUS_W - LOW_W);
         RES_MID: just = acc_i << (BUS_W - MID_W);
         default: just = acc_i;
      endcase
      word_o = just;
      if (!fmt_bin_i) word_o[BUS_W-1] = ~just[BUS_W-1];
   end
endmodule

// File: rtl/result_buffer.sv
module result_buffer #(
   parameter int unsigned BUS_W = 10,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dual_i,
   input  logic             push_i,
   input  logic [BUS_W-1:0] word_i,
   input  logic             pop_i,
   output logic [BUS_W-1:0] data_o,
   output logic [$clog2(DEPTH+1)-1:0] fill_o
);
   localparam int unsigned FW = $clog2(DEPTH + 1);

   logic [BUS_W-1:0] mem_q [DEPTH];
   logic [BUS_W-1:0] last_q;
   logic [FW-1:0]    fill_q, eff, wr_idx;
   logic             pop_ok, push_ok;

   always_comb begin
      pop_ok  = pop_i && (fill_q != '0);
      eff     = fill_q - FW'(pop_ok);
      wr_idx  = dual_i ? eff : '0;
      push_ok = push_i && (!dual_i || (eff < FW'(DEPTH)));
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [BUS_W-1:0] shifted;
      if (i + 1 < DEPTH) begin : g_mid
         assign shifted = pop_ok ? mem_q[i+1] : mem_q[i];
      end else begin : g_end
         assign shifted = mem_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem_q[i] <= '0;
         else if (push_ok && wr_idx == FW'(i))  mem_q[i] <= word_i;
         else                                   mem_q[i] <= shifted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
         last_q <= '0;
      end else begin
         if (pop_ok) last_q <= mem_q[0];
         if (push_ok) fill_q <= dual_i ? eff + FW'(1) : FW'(1);
         else         fill_q <= eff;
      end
   end

   assign data_o = (fill_q != '0) ? mem_q[0] : last_q;
   assign fill_o = fill_q;
endmodule

// File: rtl/conv_result_fmt.sv
module conv_result_fmt
   import conv_fmt_pkg::*;
#(
   parameter int unsigned BUS_W  = 10,
   parameter int unsigned PAIR_W = 2,
   parameter int unsigned MID_W  = 8,
   parameter int unsigned LOW_W  = 4,
   parameter int unsigned DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_start_i,
   input  logic [PAIR_W-1:0] pair_i,
   input  logic [1:0]        res_sel_i,
   input  logic              fmt_bin_i,
   input  logic              dual_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   output logic              done_o,
   output logic [BUS_W-1:0]  data_o,
   output logic              oe_o
);
   localparam int unsigned FW = $clog2(DEPTH + 1);

   if (BUS_W % PAIR_W != 0 || MID_W % PAIR_W != 0 || LOW_W % PAIR_W != 0)
      begin : g_bad_width  $error("widths must be multiples of the pair width"); end
   if (DEPTH < 2 || LOW_W >= MID_W || MID_W >= BUS_W)
      begin : g_bad_cfg    $error("inconsistent depth or resolution set"); end

   logic [BUS_W-1:0] acc, word;
   res_e             res_q;
   logic             fmt_q, rd_q, rd_done;
   logic [FW-1:0]    fill;

   pair_assembler #(.BUS_W(BUS_W), .PAIR_W(PAIR_W), .MID_W(MID_W), .LOW_W(LOW_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .start_i(pair_start_i), .pair_i(pair_i),
      .res_i(res_e'(res_sel_i)), .fmt_i(fmt_bin_i),
      .done_o(done_o), .acc_o(acc), .res_o(res_q), .fmt_o(fmt_q));

   result_formatter #(.BUS_W(BUS_W), .PAIR_W(PAIR_W), .MID_W(MID_W), .LOW_W(LOW_W)) u_fmt (
      .acc_i(acc), .res_i(res_q), .fmt_bin_i(fmt_q), .word_o(word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b1;
      else        rd_q <= rd_n_i;
   end
   assign rd_done = !rd_q && rd_n_i && !cs_n_i;

   result_buffer #(.BUS_W(BUS_W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .dual_i(dual_i), .push_i(done_o), .word_i(word),
      .pop_i(rd_done), .data_o(data_o), .fill_o(fill));

   assign oe_o = !cs_n_i && !rd_n_i;
endmodule

// File: rtl/conv_result_fmt_chk.sv
module conv_result_fmt_chk
   import conv_fmt_pkg::*;
#(
   parameter int unsigned BUS_W = 10,
   parameter int unsigned MID_W = 8,
   parameter int unsigned LOW_W = 4,
   parameter int unsigned DEPTH = 2,
   parameter int unsigned FW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n_i,
   input logic             oe_o,
   input logic             done_o,
   input logic [BUS_W-1:0] data_o,
   input logic [BUS_W-1:0] word,
   input res_e             res_q,
   input logic             rd_done,
   input logic [FW-1:0]    fill
);
   a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_i |-> !oe_o);
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r2_mid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && res_q == RES_MID) |-> (word[BUS_W-MID_W-1:0] == '0));
   a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && res_q == RES_LOW) |-> (word[BUS_W-LOW_W-1:0] == '0));
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));
   a_r10_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && fill == '0 && !done_o) |=> $stable(data_o));
endmodule

bind conv_result_fmt conv_result_fmt_chk #(
   .BUS_W(BUS_W), .MID_W(MID_W), .LOW_W(LOW_W), .DEPTH(DEPTH), .FW(FW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .oe_o(oe_o), .done_o(done_o),
   .data_o(data_o), .word(word), .res_q(res_q), .rd_done(rd_done), .fill(fill));

// File: tb/sim_conv_result_fmt.sv
module sim_conv_result_fmt;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       start = 1'b0, fmt = 1'b1, dual = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
   logic [1:0] pair = '0, res = '0;
   logic       done, oe;
   logic [9:0] data;
   int         checks = 0, failures = 0;
   bit         fin = 1'b0;

   always #10 clk = ~clk;

   conv_result_fmt u0 (
      .clk(clk), .rst_n(rst_n), .pair_start_i(start), .pair_i(pair),
      .res_sel_i(res), .fmt_bin_i(fmt), .dual_i(dual), .cs_n_i(cs_n),
      .rd_n_i(rd_n), .done_o(done), .data_o(data), .oe_o(oe));

   function automatic int npairs(input logic [1:0] r);
      case (r)
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 5;
      endcase
   endfunction

   function automatic logic [9:0] expect_word(input logic [1:0] r, input logic f,
                                             input logic [9:0] v);
      int n = npairs(r);
      logic [9:0] m = v & ((10'd1 << (2*n)) - 10'd1);
      logic [9:0] w = m << (10 - 2*n);
      if (!f) w[9] = ~w[9];
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // feeds the pairs of v (MSB pair first) and checks the done pulse
   task automatic convert(input logic [1:0] r, input logic f, input logic [9:0] v,
                          input string req);
      int n = npairs(r);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start = (k == 0);
         res   = r;
         fmt   = f;
         pair  = v[2*(n-1-k) +: 2];
      end
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, req, done, 1);
   endtask

   task automatic do_read(input logic [9:0] exp, input string req);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0;
      #1;
      chk(oe === 1'b1, "R6", oe, 1);
      chk(data === exp, req, data, exp);
      @(negedge clk);
      rd_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [9:0] a, b, c, v;
      logic [1:0] r;
      logic       f;
      void'($urandom(32'h1562));
      repeat (3) @(negedge clk);
      // reset state (R10)
      chk(done === 1'b0 && oe === 1'b0, "R10 reset", {done, oe}, 0);
      chk(data === 10'd0, "R10 reset data", data, 0);
      rst_n = 1'b1;

      // R6: no enable while chip select is high
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
      chk(oe === 1'b0, "R6 cs high", oe, 0);
      @(negedge clk); rd_n = 1'b1;

      // R1/R2/R3/R4/R5 directed
      convert(2'b00, 1'b1, 10'h2A5, "R1 done");  do_read(10'h2A5, "R1 word");
      convert(2'b10, 1'b1, 10'h0C3, "R2 done");  do_read(10'h30C, "R2 word");
      convert(2'b01, 1'b1, 10'h00B, "R3 done");  do_read(10'h2C0, "R3 word");
      convert(2'b11, 1'b1, 10'h155, "R4 done");  do_read(10'h155, "R4 word");
      convert(2'b00, 1'b0, 10'h3F0, "R5 done");  do_read(10'h1F0, "R5 twos");
      // R10: empty read returns last word
      do_read(10'h1F0, "R10 empty read");

      // R8: dual, ordering and drop when full
      dual = 1'b1;
      a = 10'h111; b = 10'h222; c = 10'h333;
      convert(2'b00, 1'b1, a, "R8 done a");
      convert(2'b00, 1'b1, b, "R8 done b");
      convert(2'b00, 1'b1, c, "R8 done c");
      do_read(a, "R8 first");
      do_read(b, "R8 second");
      do_read(b, "R8 dropped third / R10");

      // R7: rising strobe with chip select high pops nothing
      convert(2'b00, 1'b1, 10'h0F1, "R7 done");
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
      @(negedge clk); rd_n = 1'b1;
      @(negedge clk);
      do_read(10'h0F1, "R7 no pop with cs high");
      do_read(10'h0F1, "R7 popped once");

      // R9: single mode replaces
      dual = 1'b0;
      convert(2'b00, 1'b1, 10'h0AA, "R9 done x");
      convert(2'b00, 1'b1, 10'h355, "R9 done y");
      do_read(10'h355, "R9 replace");

      // R11: restart abandons partial result
      @(negedge clk); start = 1'b1; res = 2'b00; pair = 2'b11;
      @(negedge clk); start = 1'b0; pair = 2'b11;
      @(negedge clk); pair = 2'b11;
      chk(done === 1'b0, "R11 no early done", done, 0);
      convert(2'b10, 1'b1, 10'h05A, "R11 done");
      do_read(10'h168, "R11 word");

      // R12: resolution and format changes after start are ignored
      v = 10'h2D3;
      @(negedge clk); start = 1'b1; res = 2'b00; fmt = 1'b1; pair = v[9:8];
      @(negedge clk); start = 1'b0; res = 2'b01; fmt = 1'b0; pair = v[7:6];
      @(negedge clk); pair = v[5:4];
      chk(done === 1'b0, "R12 no done after two pairs", done, 0);
      @(negedge clk); pair = v[3:2];
      @(negedge clk); pair = v[1:0];
      @(negedge clk);
      chk(done === 1'b1, "R12 done after five", done, 1);
      @(negedge clk);
      chk(done === 1'b0, "R12 single pulse", done, 0);
      do_read(v, "R12 word");

      // random section: single mode, every resolution and coding
      for (int i = 0; i < 60; i++) begin
         r = 2'($urandom_range(0, 3));
         f = 1'($urandom_range(0, 1));
         v = 10'($urandom);
         convert(r, f, v, $sformatf("R%0d rand done", (r == 2'b01) ? 3 : (r == 2'b10) ? 2 : 1));
         @(negedge clk);
         chk(done === 1'b0, "R12 rand pulse", done, 0);
         do_read(expect_word(r, f, v), f ? "R1 R2 R3 R4 rand word" : "R5 rand word");
      end

      fin = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule